// File: doc/BRIEF.md
# Packed Integer SIMD ALU

This unit is one integer execution slot of a vector datapath. Each accepted cycle it takes two 128-bit source vectors and applies one operation to them. The operation is an add, a subtract, a bitwise AND/OR/XOR, or an equality or signed greater-than comparison. The vector is divided into lanes of 8, 16, 32 or 64 bits, and the lane size is chosen per operation at run time. Lane 0 holds the least-significant bits, and lane numbers rise toward the top bit. Arithmetic carries and borrows are cut at every lane boundary, so each lane wraps on its own.

The unit has two modes. In packed mode every lane is computed. In scalar mode only lane 0 is computed, and every result bit above lane 0 is copied from source 1. The result is registered and appears one clock after the inputs are presented with `in_valid`.

The unit accepts a new operation every cycle and has no ready signal. The consumer must take `result` in the cycle that `out_valid` is high. When no new operation arrives, `result` keeps its last value.

Top module: `simd_int_alu`

## Requirements
- R1: `lane_sel` picks the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane i occupies bits [i*w+w-1 : i*w].
- R2: `op` = 0 (add) gives each lane as (s1 + s2) mod 2^w. No carry crosses a lane boundary.
- R3: `op` = 1 (subtract) gives each lane as (s1 - s2) mod 2^w. No borrow crosses a lane boundary.
- R4: `op` = 2, 3 and 4 give bitwise AND, OR and XOR. In packed mode the result is the same for every lane size.
- R5: `op` = 5 (equal) writes all ones into a lane whose two operands are equal, and all zeros otherwise.
- R6: `op` = 6 (greater) writes all ones into a lane where s1 > s2 as signed two's complement values, and all zeros otherwise.
- R7: With `scalar` = 1, only lane 0 takes the operation result, and all higher bits equal source 1. This also applies to the logical operations.
- R8: `out_valid` is `in_valid` delayed by exactly one clock, and `result` changes only after a cycle with `in_valid` high.
- R9: A synchronous active-high `rst` clears `out_valid` and `result` to zero.
- R10: If `lane_sel` is 4 to 7 or `op` is 7, the result is all zeros, and `out_valid` is still asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls are presented this cycle |
| src1 | input | 128 | First source vector |
| src2 | input | 128 | Second source vector |
| lane_sel | input | 3 | Lane-size select (see R1, R10) |
| op | input | 3 | Operation code (see R2 to R6, R10) |
| scalar | input | 1 | 1 = lane 0 only, 0 = all lanes |
| out_valid | output | 1 | Result is valid |
| result | output | 128 | Registered result vector |

## Verification
The behaviour that is hardest to reach from the ports is a carry or borrow arriving exactly at a lane boundary. Random operands almost never do this. The bench therefore drives all-ones bytes against 0x01 bytes, and zero against 0x01 bytes, so that a leaking carry or borrow would disturb every lane boundary at every lane size. It also drives 0x80 bytes against 0x7F bytes, which puts the sign bit of every lane size in opposition for the signed comparison. These patterns, together with random and equal operands, are swept over every lane select, every opcode and both modes.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int BASE_W     = 8;
  localparam int NUM_SIZES  = 4;
  localparam int LANE_SEL_W = 3;
  localparam int OP_W       = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_CEQ = 3'd5,
    OP_CGT = 3'd6,
    OP_RSV = 3'd7
  } op_e;
endpackage

// File: rtl/simd_seg_addsub.sv
module simd_seg_addsub
  import simd_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic             sub,
  input  logic [1:0]       size,
  output logic [VEC_W-1:0] sum
);
  localparam int NBYTES = VEC_W / BASE_W;

  // Byte-sliced adder: the carry is re-seeded at each lane start.
  always_comb begin
    logic            cy;
    logic [BASE_W:0] t;
    int unsigned     span;
    span = 32'd1 << size;
    cy   = sub;
    sum  = '0;
    for (int k = 0; k < NBYTES; k++) begin
      if ((k & int'(span - 1)) == 0) cy = sub;
      t = {1'b0, a[k*BASE_W +: BASE_W]}
        + {1'b0, b[k*BASE_W +: BASE_W] ^ {BASE_W{sub}}}
        + {{BASE_W{1'b0}}, cy};
      sum[k*BASE_W +: BASE_W] = t[BASE_W-1:0];
      cy = t[BASE_W];
    end
  end
endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp
  import simd_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic [1:0]       size,
  output logic [VEC_W-1:0] eq_mask,
  output logic [VEC_W-1:0] gt_mask
);
  logic [NUM_SIZES-1:0][VEC_W-1:0] eq_all;
  logic [NUM_SIZES-1:0][VEC_W-1:0] gt_all;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int LW = BASE_W << s;
    localparam int NL = VEC_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      assign eq_all[s][l*LW +: LW] = {LW{a[l*LW +: LW] == b[l*LW +: LW]}};
      assign gt_all[s][l*LW +: LW] =
        {LW{$signed(a[l*LW +: LW]) > $signed(b[l*LW +: LW])}};
    end
  end

  assign eq_mask = eq_all[size];
  assign gt_mask = gt_all[size];
endmodule

// File: rtl/simd_int_alu.sv
module simd_int_alu
  import simd_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [VEC_W-1:0]      src1,
  input  logic [VEC_W-1:0]      src2,
  input  logic [LANE_SEL_W-1:0] lane_sel,
  input  logic [OP_W-1:0]       op,
  input  logic                  scalar,
  output logic                  out_valid,
  output logic [VEC_W-1:0]      result
);
  logic [1:0]       size;
  logic             size_ok;
  logic             op_ok;
  logic [VEC_W-1:0] arith;
  logic [VEC_W-1:0] eq_m;
  logic [VEC_W-1:0] gt_m;
  logic [VEC_W-1:0] op_res;
  logic [VEC_W-1:0] low_mask;
  logic [VEC_W-1:0] merged;
  logic [VEC_W-1:0] next_res;

  assign size    = lane_sel[1:0];
  assign size_ok = (lane_sel < LANE_SEL_W'(NUM_SIZES));
  assign op_ok   = (op != OP_RSV);

  simd_seg_addsub #(.VEC_W(VEC_W)) u_addsub (
    .a(src1), .b(src2), .sub(op == OP_SUB), .size(size), .sum(arith)
  );

  simd_lane_cmp #(.VEC_W(VEC_W)) u_cmp (
    .a(src1), .b(src2), .size(size), .eq_mask(eq_m), .gt_mask(gt_m)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: op_res = arith;
      OP_AND:         op_res = src1 & src2;
      OP_OR:          op_res = src1 | src2;
      OP_XOR:         op_res = src1 ^ src2;
      OP_CEQ:         op_res = eq_m;
      OP_CGT:         op_res = gt_m;
      default:        op_res = '0;
    endcase
  end

  // Bits covered by lane 0 at the selected size.
  assign low_mask = (VEC_W'(1) << (BASE_W << size)) - VEC_W'(1);
  assign merged   = scalar ? ((op_res & low_mask) | (src1 & ~low_mask)) : op_res;
  assign next_res = (size_ok && op_ok) ? merged : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end
endmodule

// File: rtl/simd_int_alu_chk.sv
module simd_int_alu_chk
  import simd_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [VEC_W-1:0]      src1,
  input logic [VEC_W-1:0]      src2,
  input logic [LANE_SEL_W-1:0] lane_sel,
  input logic [OP_W-1:0]       op,
  input logic                  scalar,
  input logic                  out_valid,
  input logic [VEC_W-1:0]      result
);
  function automatic logic bytes_saturated(input logic [VEC_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < VEC_W / BASE_W; k++)
      if (v[k*BASE_W +: BASE_W] != '0 && v[k*BASE_W +: BASE_W] != '1) ok = 1'b0;
    return ok;
  endfunction

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));
  // R10
  rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == OP_RSV || lane_sel >= LANE_SEL_W'(NUM_SIZES)))
      |=> (out_valid && result == '0));
  // R7
  scalar_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && scalar && op != OP_RSV && lane_sel < LANE_SEL_W'(NUM_SIZES))
      |=> result[VEC_W-1:64] == $past(src1[VEC_W-1:64]));
  // R4
  and_packed_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !scalar && op == OP_AND && lane_sel < LANE_SEL_W'(NUM_SIZES))
      |=> result == $past(src1 & src2));
  // R5
  cmp_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !scalar && op == OP_CEQ && lane_sel == '0)
      |=> bytes_saturated(result));
endmodule

bind simd_int_alu simd_int_alu_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .src1(src1), .src2(src2),
  .lane_sel(lane_sel), .op(op), .scalar(scalar),
  .out_valid(out_valid), .result(result)
);

// File: tb/simd_int_alu_tb.sv
module simd_int_alu_tb;
  localparam int CLK_P = 10;
  localparam int W = 128;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [W-1:0] src1, src2;
  logic [2:0]   lane_sel;
  logic [2:0]   op;
  logic         scalar;
  logic         out_valid;
  logic [W-1:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  simd_int_alu #(.VEC_W(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src1(src1), .src2(src2),
    .lane_sel(lane_sel), .op(op), .scalar(scalar),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input int sz, input int o, input bit sc);
    logic [W-1:0] r, m, x, y, v, sb;
    int lw, nl;
    if (sz > 3 || o == 7) return '0;
    lw = 8 << sz;
    nl = sc ? 1 : W / lw;
    m  = (W'(1) << lw) - 1;
    sb = W'(1) << (lw - 1);
    r  = sc ? a : '0;
    for (int l = 0; l < nl; l++) begin
      x = (a >> (l*lw)) & m;
      y = (b >> (l*lw)) & m;
      case (o)
        0: v = (x + y) & m;
        1: v = (x - y) & m;
        2: v = x & y;
        3: v = x | y;
        4: v = x ^ y;
        5: v = (x == y) ? m : '0;
        default: v = ((x ^ sb) > (y ^ sb)) ? m : '0;
      endcase
      r = (r & ~(m << (l*lw))) | (v << (l*lw));
    end
    return r;
  endfunction

  function automatic string tag(input int sz, input int o, input bit sc);
    if (sz > 3 || o == 7) return "R10";
    if (sc) return "R7";
    case (o)
      0: return "R2";
      1: return "R3";
      2, 3, 4: return "R4";
      5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Drive one operation; compare one clock later at the falling edge.
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input int sz, input int o, input bit sc);
    @(negedge clk);
    src1 = a; src2 = b; lane_sel = 3'(sz); op = 3'(o); scalar = sc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", {127'b0, out_valid}, {127'b0, 1'b1});
    check(tag(sz, o, sc), result, model(a, b, sz, o, sc));
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b, hold;
    rst = 1'b1; in_valid = 1'b0; src1 = '0; src2 = '0;
    lane_sel = '0; op = '0; scalar = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    check("R9", {127'b0, out_valid}, '0);
    check("R9", result, '0);

    // R1..R7, R10: sweep every lane select, opcode and mode
    for (int sz = 0; sz < 8; sz++)
      for (int o = 0; o < 8; o++)
        for (int sc = 0; sc < 2; sc++)
          for (int p = 0; p < 6; p++) begin
            case (p)
              0: begin a = {16{8'hFF}}; b = {16{8'h01}}; end
              1: begin a = '0;          b = {16{8'h01}}; end
              2: begin a = {16{8'h80}}; b = {16{8'h7F}}; end
              3: begin a = rnd128();    b = a ^ (W'(1) << (p*17)); end
              4: begin a = rnd128();    b = a; end
              default: begin a = rnd128(); b = rnd128(); end
            endcase
            run_op(a, b, sz, o, sc[0]);
          end

    // R8: idle cycle leaves result unchanged and out_valid low
    hold = result;
    @(negedge clk);
    src1 = rnd128(); src2 = rnd128(); op = 3'd4;
    check("R8", {127'b0, out_valid}, '0);
    check("R8", result, hold);

    // R8: back-to-back operations
    @(negedge clk);
    a = rnd128(); b = rnd128();
    src1 = a; src2 = b; lane_sel = 3'd1; op = 3'd0; scalar = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check("R8", result, model(a, b, 1, 0, 1'b0));
    src1 = b; src2 = a; op = 3'd1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", {127'b0, out_valid}, {127'b0, 1'b1});
    check("R8", result, model(b, a, 1, 1, 1'b0));

    // R9: reset in mid-run
    run_op(rnd128(), rnd128(), 2, 4, 1'b0);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    check("R9", {127'b0, out_valid}, '0);
    check("R9", result, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule